// File: doc/BRIEF.md
# Block Control Word Decoder and Row Sequencer

This block sits on the receive side of a serial display link. It takes 192-bit control words from the channel 0 side-band control stream, validates them, pulls out the operation fields, and then steps through the rows of one addressed block of the mirror array. Words that arrive on the three auxiliary channels are accepted and thrown away.

A load operation writes a number of rows taken from the word. The walk starts at the bottom row and counts up, or starts at the top row and counts down, depending on a direction bit. The row address moves on only in a cycle where the pixel path reports that a row of data is available. A clear or a set operation is issued as a single block-wide command. Every operation ends with a one-cycle done pulse. While an operation runs, the channel 0 ready output stays low, so the next word is held off until the current operation has finished.

Top module: `ctrlword_row_seq`

## Requirements
- R1: A channel 0 word whose bits [7:0] are not 0x00 is discarded completely. It causes no error pulse and no command or row write, ready stays high, and the latched block address, segment and single-channel outputs do not change.
- R2: A load word (bits [34:32] = 000) with a row count (bits [24:16]) from 1 to ROWS (136) produces exactly that many row writes. The done pulse is high for one cycle, in the cycle after the clock edge that takes the last row write.
- R3: Direction bit [36] = 0 makes a load write rows 1, 2, 3 and so on upward. Bit [36] = 1 makes it write rows ROWS, ROWS-1 and so on downward.
- R4: A load word with a row count of 0 or above ROWS is dropped. It causes no row write, and `err` is high for one cycle, in the cycle after the word is accepted.
- R5: A word with a reserved operation code (3 to 7) is dropped in the same way, with a one-cycle `err` pulse.
- R6: Clear (001) and set (010) ignore the row-count and direction fields. `blk_cmd_valid` is high for exactly the cycle after acceptance, with `blk_cmd_fill` = 0 for clear and 1 for set. `done` follows in the next cycle, and no row write occurs.
- R7: On each accepted legal word, `blk_addr` takes bits [11:8] and `single_ch` takes bit [30]. `seg_sel` takes bits [29:28] when bit [30] is 1, and is 0 otherwise.
- R8: `aux_ready` is always all ones. Words on the auxiliary channels have no effect on any other output.
- R9: `ch0_ready` goes low in the cycle after a legal word is accepted. It stays low until it rises in the same cycle as `done`.
- R10: During a load, `row_wr` follows `row_avail`. The row address holds its value in every cycle in which `row_avail` is low.
- R11: After reset, `ch0_ready` and `aux_ready` are high, and `row_wr`, `blk_cmd_valid`, `done`, `err`, `blk_addr`, `seg_sel` and `single_ch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch0_valid | input | 1 | Channel 0 control word valid |
| ch0_data | input | 192 | Channel 0 control word |
| ch0_ready | output | 1 | Channel 0 word accepted when valid is also high |
| aux_valid | input | NUM_AUX | Auxiliary channel word valids (ignored) |
| aux_data | input | NUM_AUX*192 | Auxiliary channel words (ignored) |
| aux_ready | output | NUM_AUX | Always high |
| row_avail | input | 1 | One row of pixel data is available this cycle |
| row_wr | output | 1 | Row write strobe |
| row_addr | output | ROW_W | Row being written, 1-based |
| blk_addr | output | 4 | Addressed array block |
| blk_cmd_valid | output | 1 | Block-wide clear or set command |
| blk_cmd_fill | output | 1 | 0 for clear, 1 for set |
| seg_sel | output | 2 | Segment select, valid in single-channel mode |
| single_ch | output | 1 | Single-channel mode flag |
| done | output | 1 | Operation complete pulse |
| err | output | 1 | Illegal word dropped pulse |

## Verification
The bench builds the block with its default parameters: ROWS = 136 and three auxiliary channels. With these values a full-length load runs across every row in both directions, and the count limits of 136 (accepted) and 137 (rejected) sit exactly at the edge of the range. The count of 0 and the reserved operation codes complete the set of rejected words. Loads run with `row_avail` held high and with `row_avail` toggling, so the hold behaviour between rows is visible at the ports.

// File: rtl/cwrs_pkg.sv
package cwrs_pkg;

    localparam int CW_W     = 192;
    localparam int CNT_FW   = 9;
    localparam int BLK_FW   = 4;
    localparam int SEG_FW   = 2;
    localparam int OP_FW    = 3;

    localparam logic [OP_FW-1:0] OP_LOAD  = 3'd0;
    localparam logic [OP_FW-1:0] OP_CLEAR = 3'd1;
    localparam logic [OP_FW-1:0] OP_SET   = 3'd2;

    typedef struct packed {
        logic [7:0]        hdr;
        logic [BLK_FW-1:0] blk;
        logic [CNT_FW-1:0] rows;
        logic [SEG_FW-1:0] seg;
        logic              single;
        logic [OP_FW-1:0]  op;
        logic              flip;
    } cw_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_CMD  = 2'd2
    } seq_state_t;

    function automatic cw_fields_t cw_extract(input logic [CW_W-1:0] w);
        cw_fields_t f;
        f.hdr    = w[7:0];
        f.blk    = w[11:8];
        f.rows   = w[24:16];
        f.seg    = w[29:28];
        f.single = w[30];
        f.op     = w[34:32];
        f.flip   = w[36];
        return f;
    endfunction

endpackage

// File: rtl/cw_decode.sv
module cw_decode
    import cwrs_pkg::*;
#(
    parameter int ROWS = 136
) (
    input  logic [CW_W-1:0] word,
    output cw_fields_t      fields,
    output logic            hdr_ok,
    output logic            legal,
    output logic            is_load,
    output logic            is_fill
);
    localparam logic [CNT_FW-1:0] MAX_ROWS = CNT_FW'(ROWS);

    logic count_ok;
    logic unused_bits;

    assign unused_bits = ^{word[CW_W-1:37], word[35], word[31], word[27:25], word[15:12]};

    always_comb begin
        fields   = cw_extract(word);
        hdr_ok   = (fields.hdr == 8'h00);
        count_ok = (fields.rows != '0) && (fields.rows <= MAX_ROWS);
        is_load  = (fields.op == OP_LOAD);
        is_fill  = (fields.op == OP_SET);
        unique case (fields.op)
            OP_LOAD:           legal = count_ok;
            OP_CLEAR, OP_SET:  legal = 1'b1;
            default:           legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/row_walker.sv
module row_walker #(
    parameter int ROWS  = 136,
    parameter int ROW_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             flip,
    input  logic [ROW_W-1:0] count,
    input  logic             step,
    output logic [ROW_W-1:0] addr,
    output logic             last
);
    localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(ROWS);
    localparam logic [ROW_W-1:0] ONE     = ROW_W'(1);

    logic [ROW_W-1:0] left;
    logic             down;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            left <= '0;
            down <= 1'b0;
        end else if (start) begin
            addr <= flip ? TOP_ROW : ONE;
            left <= count;
            down <= flip;
        end else if (step) begin
            addr <= down ? (addr - ONE) : (addr + ONE);
            left <= left - ONE;
        end
    end

    assign last = (left == ONE);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import cwrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic legal,
    input  logic is_load,
    input  logic row_avail,
    input  logic last,
    output logic ready,
    output logic start_load,
    output logic step,
    output logic cmd_active,
    output logic done,
    output logic err
);
    seq_state_t st;

    assign ready      = (st == ST_IDLE);
    assign start_load = take && legal && is_load;
    assign step       = (st == ST_LOAD) && row_avail;
    assign cmd_active = (st == ST_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (take) begin
                        if (!legal)       err <= 1'b1;
                        else if (is_load) st  <= ST_LOAD;
                        else              st  <= ST_CMD;
                    end
                end
                ST_LOAD: begin
                    if (row_avail && last) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                ST_CMD: begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ctrlword_row_seq.sv
module ctrlword_row_seq
    import cwrs_pkg::*;
#(
    parameter int ROWS    = 136,
    parameter int NUM_AUX = 3,
    parameter int ROW_W   = $clog2(ROWS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ch0_valid,
    input  logic [CW_W-1:0]         ch0_data,
    output logic                    ch0_ready,
    input  logic [NUM_AUX-1:0]      aux_valid,
    input  logic [NUM_AUX*CW_W-1:0] aux_data,
    output logic [NUM_AUX-1:0]      aux_ready,
    input  logic                    row_avail,
    output logic                    row_wr,
    output logic [ROW_W-1:0]        row_addr,
    output logic [BLK_FW-1:0]       blk_addr,
    output logic                    blk_cmd_valid,
    output logic                    blk_cmd_fill,
    output logic [SEG_FW-1:0]       seg_sel,
    output logic                    single_ch,
    output logic                    done,
    output logic                    err
);
    cw_fields_t f;
    logic hdr_ok, legal, is_load, is_fill;
    logic take, start_load, last;
    logic unused_aux;

    assign unused_aux = ^{aux_valid, aux_data};

    generate
        for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
            assign aux_ready[i] = 1'b1;
        end
    endgenerate

    cw_decode #(.ROWS(ROWS)) u_dec (
        .word    (ch0_data),
        .fields  (f),
        .hdr_ok  (hdr_ok),
        .legal   (legal),
        .is_load (is_load),
        .is_fill (is_fill)
    );

    assign take = ch0_valid && ch0_ready && hdr_ok;

    seq_ctrl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .legal      (legal),
        .is_load    (is_load),
        .row_avail  (row_avail),
        .last       (last),
        .ready      (ch0_ready),
        .start_load (start_load),
        .step       (row_wr),
        .cmd_active (blk_cmd_valid),
        .done       (done),
        .err        (err)
    );

    row_walker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_walk (
        .clk   (clk),
        .rst   (rst),
        .start (start_load),
        .flip  (f.flip),
        .count (f.rows[ROW_W-1:0]),
        .step  (row_wr),
        .addr  (row_addr),
        .last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_addr     <= '0;
            seg_sel      <= '0;
            single_ch    <= 1'b0;
            blk_cmd_fill <= 1'b0;
        end else if (take && legal) begin
            blk_addr     <= f.blk;
            seg_sel      <= f.single ? f.seg : '0;
            single_ch    <= f.single;
            blk_cmd_fill <= is_fill;
        end
    end

endmodule

// File: rtl/cwrs_checker.sv
module cwrs_checker #(
    parameter int ROWS    = 136,
    parameter int NUM_AUX = 3,
    parameter int ROW_W   = $clog2(ROWS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               ch0_valid,
    input logic [7:0]         hdr_byte,
    input logic               ch0_ready,
    input logic [NUM_AUX-1:0] aux_ready,
    input logic               row_wr,
    input logic [ROW_W-1:0]   row_addr,
    input logic               blk_cmd_valid,
    input logic [1:0]         seg_sel,
    input logic               single_ch,
    input logic               done,
    input logic               err
);
    assert_hdr_discard_R1: assert property (@(posedge clk) disable iff (rst)
        ch0_valid && ch0_ready && (hdr_byte != 8'h00) |=> ch0_ready && !err && !blk_cmd_valid);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_row_range_R3: assert property (@(posedge clk) disable iff (rst)
        row_wr |-> (row_addr >= ROW_W'(1)) && (row_addr <= ROW_W'(ROWS)));

    assert_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> ch0_ready && !done && !row_wr);

    assert_err_single_R5: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_cmd_done_R6: assert property (@(posedge clk) disable iff (rst)
        blk_cmd_valid |=> done && !blk_cmd_valid);

    assert_seg_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (seg_sel != 2'b00) |-> single_ch);

    assert_aux_ready_R8: assert property (@(posedge clk) disable iff (rst)
        aux_ready == {NUM_AUX{1'b1}});

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (row_wr || blk_cmd_valid) |-> !ch0_ready);

    assert_row_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ch0_ready && !row_wr && !blk_cmd_valid |=> $stable(row_addr));

endmodule

bind ctrlword_row_seq cwrs_checker #(.ROWS(ROWS), .NUM_AUX(NUM_AUX), .ROW_W(ROW_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ch0_valid     (ch0_valid),
    .hdr_byte      (ch0_data[7:0]),
    .ch0_ready     (ch0_ready),
    .aux_ready     (aux_ready),
    .row_wr        (row_wr),
    .row_addr      (row_addr),
    .blk_cmd_valid (blk_cmd_valid),
    .seg_sel       (seg_sel),
    .single_ch     (single_ch),
    .done          (done),
    .err           (err)
);

// File: tb/tb_ctrlword_row_seq.sv
module tb_ctrlword_row_seq;
    localparam int ROWS    = 136;
    localparam int NUM_AUX = 3;
    localparam int ROW_W   = $clog2(ROWS + 1);
    localparam int CW      = 192;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    ch0_valid = 1'b0;
    logic [CW-1:0]           ch0_data = '0;
    logic                    ch0_ready;
    logic [NUM_AUX-1:0]      aux_valid = '0;
    logic [NUM_AUX*CW-1:0]   aux_data = '0;
    logic [NUM_AUX-1:0]      aux_ready;
    logic                    row_avail = 1'b0;
    logic                    row_wr;
    logic [ROW_W-1:0]        row_addr;
    logic [3:0]              blk_addr;
    logic                    blk_cmd_valid;
    logic                    blk_cmd_fill;
    logic [1:0]              seg_sel;
    logic                    single_ch;
    logic                    done;
    logic                    err;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ctrlword_row_seq #(.ROWS(ROWS), .NUM_AUX(NUM_AUX)) dut (.*);

    function automatic logic [CW-1:0] mk(input logic [7:0] hdr, input logic [3:0] blk,
                                         input logic [8:0] cnt, input logic [1:0] seg,
                                         input logic single, input logic [2:0] op,
                                         input logic flip);
        logic [CW-1:0] w;
        w = '0;
        w[CW-1:180] = '1;
        w[15:12]    = 4'hA;
        w[7:0]      = hdr;
        w[11:8]     = blk;
        w[24:16]    = cnt;
        w[29:28]    = seg;
        w[30]       = single;
        w[34:32]    = op;
        w[36]       = flip;
        return w;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [CW-1:0] w);
        @(negedge clk);
        ch0_valid = 1'b1;
        ch0_data  = w;
        @(negedge clk);
        ch0_valid = 1'b0;
        ch0_data  = '0;
    endtask

    task automatic t_reset();
        chk("R11", "ready", ch0_ready, 1);
        chk("R11", "aux_ready", aux_ready, 7);
        chk("R11", "row_wr", row_wr, 0);
        chk("R11", "cmd", blk_cmd_valid, 0);
        chk("R11", "done", done, 0);
        chk("R11", "err", err, 0);
        chk("R11", "blk", blk_addr, 0);
        chk("R11", "seg", seg_sel, 0);
        chk("R11", "single", single_ch, 0);
    endtask

    task automatic t_load(input logic [3:0] blk, input int cnt, input logic flip,
                          input bit gaps, input logic [1:0] seg, input logic single);
        int e;
        int written;
        int cyc;
        send(mk(8'h00, blk, 9'(cnt), seg, single, 3'd0, flip));
        chk("R9", "ready low after load accept", ch0_ready, 0);
        chk("R7", "blk_addr", blk_addr, blk);
        chk("R7", "single", single_ch, single);
        chk("R7", "seg", seg_sel, single ? seg : 0);
        e = flip ? ROWS : 1;
        written = 0;
        cyc = 0;
        while (written < cnt) begin
            row_avail = gaps ? cyc[0] : 1'b1;
            #1;
            chk("R10", "row_wr follows avail", row_wr, row_avail);
            chk("R3", "row_addr", row_addr, e);
            chk("R2", "no early done", done, 0);
            chk("R9", "ready held low", ch0_ready, 0);
            @(negedge clk);
            if (row_avail) begin
                written++;
                e = flip ? e - 1 : e + 1;
            end
            cyc++;
        end
        row_avail = 1'b0;
        #1;
        chk("R2", "done after last row", done, 1);
        chk("R9", "ready with done", ch0_ready, 1);
        chk("R2", "no write after last", row_wr, 0);
        @(negedge clk);
        chk("R2", "done one cycle", done, 0);
    endtask

    task automatic t_fill(input logic [3:0] blk, input logic is_set);
        send(mk(8'h00, blk, 9'd0, 2'd3, 1'b0, is_set ? 3'd2 : 3'd1, 1'b1));
        row_avail = 1'b1;
        #1;
        chk("R6", "cmd valid", blk_cmd_valid, 1);
        chk("R6", "fill", blk_cmd_fill, is_set);
        chk("R6", "no row write", row_wr, 0);
        chk("R6", "no err on count 0", err, 0);
        chk("R9", "ready low", ch0_ready, 0);
        chk("R7", "blk_addr", blk_addr, blk);
        chk("R7", "seg zero when not single", seg_sel, 0);
        @(negedge clk);
        chk("R6", "cmd one cycle", blk_cmd_valid, 0);
        chk("R6", "done", done, 1);
        chk("R6", "no row write", row_wr, 0);
        chk("R9", "ready back", ch0_ready, 1);
        row_avail = 1'b0;
        @(negedge clk);
        chk("R6", "done one cycle", done, 0);
    endtask

    task automatic t_bad(input string req, input logic [8:0] cnt, input logic [2:0] op);
        logic [3:0] prev_blk;
        prev_blk = blk_addr;
        send(mk(8'h00, 4'd9, cnt, 2'd1, 1'b1, op, 1'b0));
        row_avail = 1'b1;
        #1;
        chk(req, "err pulse", err, 1);
        chk(req, "ready stays", ch0_ready, 1);
        chk(req, "no row write", row_wr, 0);
        chk(req, "no cmd", blk_cmd_valid, 0);
        chk(req, "blk unchanged", blk_addr, prev_blk);
        @(negedge clk);
        chk(req, "err one cycle", err, 0);
        chk(req, "no row write later", row_wr, 0);
        row_avail = 1'b0;
    endtask

    task automatic t_header();
        logic [3:0] prev_blk;
        prev_blk = blk_addr;
        send(mk(8'h01, 4'd14, 9'd4, 2'd2, 1'b1, 3'd0, 1'b0));
        row_avail = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R1", "no err", err, 0);
            chk("R1", "ready", ch0_ready, 1);
            chk("R1", "no row write", row_wr, 0);
            chk("R1", "no cmd", blk_cmd_valid, 0);
            chk("R1", "no done", done, 0);
            @(negedge clk);
        end
        row_avail = 1'b0;
        chk("R1", "blk unchanged", blk_addr, prev_blk);
        chk("R1", "single unchanged", single_ch, 0);
        send(mk(8'h80, 4'd2, 9'd0, 2'd0, 1'b0, 3'd1, 1'b0));
        #1;
        chk("R1", "clear with bad hdr no cmd", blk_cmd_valid, 0);
        chk("R1", "clear with bad hdr blk", blk_addr, prev_blk);
    endtask

    task automatic t_aux();
        logic [3:0] prev_blk;
        prev_blk = blk_addr;
        @(negedge clk);
        aux_valid = '1;
        for (int k = 0; k < NUM_AUX; k++)
            aux_data[k*CW +: CW] = mk(8'h00, 4'd7, 9'd0, 2'd0, 1'b0, 3'd2, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8", "aux_ready", aux_ready, 7);
            chk("R8", "no cmd", blk_cmd_valid, 0);
            chk("R8", "ready", ch0_ready, 1);
            chk("R8", "blk unchanged", blk_addr, prev_blk);
        end
        aux_valid = '0;
        aux_data  = '0;
        @(negedge clk);
        chk("R8", "no done", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_header();
        t_load(4'd1, ROWS, 1'b0, 1'b0, 2'd2, 1'b0);
        t_load(4'd5, 5, 1'b1, 1'b1, 2'd2, 1'b1);
        t_load(4'd15, 1, 1'b0, 1'b1, 2'd1, 1'b1);
        t_load(4'd3, ROWS, 1'b1, 1'b0, 2'd0, 1'b0);
        t_fill(4'd6, 1'b0);
        t_fill(4'd11, 1'b1);
        t_bad("R4", 9'd0, 3'd0);
        t_bad("R4", 9'd137, 3'd0);
        t_bad("R5", 9'd10, 3'd3);
        t_bad("R5", 9'd10, 3'd7);
        t_aux();
        t_header();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule